// File: doc/BRIEF.md
# Read-to-Set Hardware Lock Bank

This block is a bus slave that holds a bank of 32-bit lock words shared by several processors for mutual exclusion. Any processor can claim a lock with an ordinary load. The read hands back the word's current contents. In the same access, the word is overwritten with the value 1, which means "taken". A returned 0 therefore means the caller now owns the lock. A returned 1 means another master already held it.

Software builds three operations on this behaviour:
- a blocking acquire, which repeats the read until it returns 0;
- a non-blocking try, which is a single read;
- a release, which is a store of 0.

The bus fabric grants at most one access per cycle. Two masters therefore can never both see 0 from the same word.

The slave port is a simple select/ready interface. The decoder of the reserved address window drives the select. A selected cycle is one access. Ready answers it exactly one cycle later, together with the read data. The number of lock words is a parameter, 32 by default.

Top module: `hw_lock_bank`

## Requirements
- R1: After reset, every lock word holds 0, and both bus_ready and bus_rdata are 0.
- R2: Each cycle with bus_sel high is one access. bus_ready is high in the cycle that follows it, and only then.
- R3: A read of an in-range word returns, in its ready cycle, the contents the word had before the read.
- R4: After a read, the word holds 1 (taken). An immediate second read of it returns 1.
- R5: A write stores bus_wdata unchanged. A later read returns the stored value. The ready cycle of a write carries bus_rdata = 0.
- R6: Writing 0 releases a lock, so the next read returns 0 and takes the lock again.
- R7: The word index is bus_addr[ADDR_W-1:2]. Address bits [1:0] are ignored.
- R8: An access whose word index is NUM_LOCKS or above returns 0 and changes no lock word.
- R9: Two back-to-back reads of the same free word, in consecutive cycles, return 0 and then 1.
- R10: An access to one word leaves every other word unchanged.
- R11: Cycles with bus_sel low change no word. The following cycle shows bus_ready = 0 and bus_rdata = 0, whatever bus_we, bus_addr and bus_wdata carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Access strobe from the window decoder |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_we | input | 1 | 1 = write, 0 = read (test-and-set) |
| bus_wdata | input | 32 | Data to store on a write |
| bus_rdata | output | 32 | Read result, valid while bus_ready is high |
| bus_ready | output | 1 | Response strobe, one cycle after bus_sel |

## Verification
The assertions check these properties on every cycle:
- the one-cycle ready timing;
- the zero response for writes, idle cycles and out-of-range addresses;
- that a read directly after a read of the same word returns 1;
- that a read directly after a write returns the written data.

Some behaviour only the bench scenarios can show. This covers state held across idle gaps and reset, the ignored low address bits, the independence of separate words, and the acquire/release/acquire sequence.

// File: rtl/hwlock_pkg.sv
package hwlock_pkg;

    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t LOCK_FREE  = 32'd0;
    localparam word_t LOCK_TAKEN = 32'd1;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Value a lock word takes after an access that hits it.
    function automatic word_t lock_update(op_e op, word_t cur, word_t wd);
        word_t nxt;
        case (op)
            OP_READ:  nxt = LOCK_TAKEN;
            OP_WRITE: nxt = wd;
            default:  nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/hwlock_decode.sv
module hwlock_decode
    import hwlock_pkg::*;
#(
    parameter int NUM_LOCKS = 32,
    parameter int ADDR_W    = 8,
    localparam int IDX_W    = ADDR_W - 2
) (
    input  logic                 sel,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_LOCKS-1:0] hit,
    output logic [IDX_W-1:0]     idx,
    output logic                 in_range,
    output op_e                  op
);

    logic unused_byte_lane;
    assign unused_byte_lane = ^addr[1:0];

    assign idx      = addr[ADDR_W-1:2];
    assign in_range = (int'(idx) < NUM_LOCKS);

    always_comb begin
        if (!sel)    op = OP_NONE;
        else if (we) op = OP_WRITE;
        else         op = OP_READ;
    end

    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_hit
        assign hit[i] = sel && in_range && (int'(idx) == i);
    end

endmodule

// File: rtl/hwlock_cell.sv
module hwlock_cell
    import hwlock_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hit,
    input  op_e   op,
    input  word_t wdata,
    output word_t value
);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= LOCK_FREE;
        end else if (hit) begin
            value <= lock_update(op, value, wdata);
        end
    end

endmodule

// File: rtl/hwlock_rdmux.sv
module hwlock_rdmux
    import hwlock_pkg::*;
#(
    parameter int NUM_LOCKS = 32,
    parameter int IDX_W     = 6
) (
    input  word_t [NUM_LOCKS-1:0] values,
    input  logic  [IDX_W-1:0]     idx,
    input  logic                  in_range,
    output word_t                 data
);

    always_comb begin
        data = LOCK_FREE;
        for (int i = 0; i < NUM_LOCKS; i++) begin
            if (in_range && (int'(idx) == i)) data = values[i];
        end
    end

endmodule

// File: rtl/hw_lock_bank.sv
module hw_lock_bank
    import hwlock_pkg::*;
#(
    parameter int NUM_LOCKS = 32,
    parameter int ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ready
);

    localparam int IDX_W = ADDR_W - 2;

    logic [NUM_LOCKS-1:0]  hit;
    logic [IDX_W-1:0]      idx;
    logic                  in_range;
    op_e                   op;
    word_t [NUM_LOCKS-1:0] values;
    word_t                 mux_data;
    word_t                 rdata_q;
    logic                  ready_q;

    hwlock_decode #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) u_dec (
        .sel      (bus_sel),
        .we       (bus_we),
        .addr     (bus_addr),
        .hit      (hit),
        .idx      (idx),
        .in_range (in_range),
        .op       (op)
    );

    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_cell
        hwlock_cell u_cell (
            .clk   (clk),
            .rst   (rst),
            .hit   (hit[i]),
            .op    (op),
            .wdata (bus_wdata),
            .value (values[i])
        );
    end

    hwlock_rdmux #(.NUM_LOCKS(NUM_LOCKS), .IDX_W(IDX_W)) u_mux (
        .values   (values),
        .idx      (idx),
        .in_range (in_range),
        .data     (mux_data)
    );

    // The old value is captured at the same edge that writes TAKEN.
    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= 1'b0;
            rdata_q <= LOCK_FREE;
        end else begin
            ready_q <= bus_sel;
            rdata_q <= (op == OP_READ) ? mux_data : LOCK_FREE;
        end
    end

    assign bus_rdata = rdata_q;
    assign bus_ready = ready_q;

endmodule

// File: rtl/hw_lock_bank_chk.sv
module hw_lock_bank_chk
    import hwlock_pkg::*;
#(
    parameter int NUM_LOCKS = 32,
    parameter int ADDR_W    = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              bus_ready
);

    logic [ADDR_W-3:0] widx;
    logic              in_rng;
    logic [1:0]        prime_cnt;

    assign widx   = bus_addr[ADDR_W-1:2];
    assign in_rng = (int'(widx) < NUM_LOCKS);

    always_ff @(posedge clk) begin
        if (rst)                 prime_cnt <= 2'd0;
        else if (prime_cnt != 2) prime_cnt <= prime_cnt + 2'd1;
    end

    assert_ready_follows_R2: assert property (@(posedge clk) disable iff (rst)
        bus_sel |=> bus_ready);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |=> (!bus_ready && bus_rdata == 32'd0));

    assert_write_resp_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we) |=> bus_rdata == 32'd0);

    assert_out_range_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !in_rng) |=> bus_rdata == 32'd0);

    assert_reread_taken_R4: assert property (@(posedge clk) disable iff (rst)
        (prime_cnt != 0 && $past(bus_sel && !bus_we) && bus_sel && !bus_we
         && in_rng && widx == $past(widx)) |=> bus_rdata == LOCK_TAKEN);

    assert_write_readback_R5: assert property (@(posedge clk) disable iff (rst)
        (prime_cnt == 2 && $past(bus_sel && bus_we) && bus_sel && !bus_we
         && in_rng && widx == $past(widx)) |=> bus_rdata == $past(bus_wdata, 2));

endmodule

bind hw_lock_bank hw_lock_bank_chk #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready)
);

// File: tb/hw_lock_bank_test.sv
module hw_lock_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 14;

    // {we, addr[7:0], wdata[31:0], expected rdata[31:0]}
    localparam logic [72:0] VEC [NVEC] = '{
        {1'b0, 8'h00, 32'h0,         32'h0},          // R3 free word reads 0
        {1'b0, 8'h00, 32'h0,         32'h1},          // R4 now taken
        {1'b1, 8'h00, 32'h0,         32'h0},          // R6 release, R5 write resp 0
        {1'b0, 8'h00, 32'h0,         32'h0},          // R6 free again
        {1'b1, 8'h04, 32'hA5A51234,  32'h0},          // R5 store data
        {1'b0, 8'h04, 32'h0,         32'hA5A51234},   // R5 read back
        {1'b0, 8'h04, 32'h0,         32'h1},          // R4 taken after read
        {1'b0, 8'h07, 32'h0,         32'h1},          // R7 low bits ignored
        {1'b1, 8'h7E, 32'hDEADBEEF,  32'h0},          // R7 last word, odd lane
        {1'b0, 8'h7C, 32'h0,         32'hDEADBEEF},   // R7 read back
        {1'b0, 8'h80, 32'h0,         32'h0},          // R8 out of range read
        {1'b1, 8'h80, 32'h5,         32'h0},          // R8 out of range write
        {1'b0, 8'h80, 32'h0,         32'h0},          // R8 still 0
        {1'b0, 8'h08, 32'h0,         32'h0}           // R10 neighbour untouched
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel;
    logic [7:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_ready;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hw_lock_bank uut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready)
    );

    function automatic string vec_req(int n);
        case (n)
            0:          return "R3";
            1, 6:       return "R4";
            2, 3:       return "R6";
            4, 5:       return "R5";
            7, 8, 9:    return "R7";
            10, 11, 12: return "R8";
            default:    return "R10";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, sample the response at the next falling edge.
    task automatic access(logic we, logic [7:0] addr, logic [31:0] wd,
                          logic [31:0] exp, string req);
        bus_sel = 1'b1; bus_we = we; bus_addr = addr; bus_wdata = wd;
        @(negedge clk);
        bus_sel = 1'b0;
        check({req, " ready"}, {31'd0, bus_ready}, 32'd1);
        check(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: outputs after reset
        check("R1 ready", {31'd0, bus_ready}, 32'd0);
        check("R1 rdata", bus_rdata, 32'd0);
        @(negedge clk);
        // R2: no ready without select
        check("R2 idle", {31'd0, bus_ready}, 32'd0);

        for (int n = 0; n < NVEC; n++) begin
            access(VEC[n][72], VEC[n][71:64], VEC[n][63:32], VEC[n][31:0], vec_req(n));
        end

        // R9: back-to-back reads of a free word
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 8'h14;
        @(negedge clk);
        check("R9 ready1", {31'd0, bus_ready}, 32'd1);
        check("R9 first", bus_rdata, 32'd0);
        @(negedge clk);
        bus_sel = 1'b0;
        check("R9 ready2", {31'd0, bus_ready}, 32'd1);
        check("R9 second", bus_rdata, 32'd1);
        @(negedge clk);
        check("R2 drop", {31'd0, bus_ready}, 32'd0);

        // R11: unselected cycles with write-like inputs are ignored
        access(1'b1, 8'h18, 32'h55, 32'h0, "R5");
        bus_we = 1'b1; bus_addr = 8'h18; bus_wdata = 32'hFF;
        repeat (3) @(negedge clk);
        check("R11 rdata", bus_rdata, 32'd0);
        check("R11 ready", {31'd0, bus_ready}, 32'd0);
        access(1'b0, 8'h18, 32'h0, 32'h55, "R11");

        // R1: reset in mid-run clears held words
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        access(1'b0, 8'h04, 32'h0, 32'h0, "R1");
        access(1'b0, 8'h7C, 32'h0, 32'h0, "R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule